// File: doc/BRIEF.md
# GPIO Sticky-Status and Wake-Up Controller

This block handles GPIO input events for a codec attached to a serial audio link. Each implemented pin has a bit in a wake-enable mask and a bit in a status register. A pin set up as a sticky input latches a transition into its status bit. The pin's polarity picks which transition counts. The bit then holds until software writes a zero to it. Every other pin shows its synchronised live level in the status register.

When a latched, wake-enabled event is pending, the block raises a wake request. The route of that request depends on link power. While the link is powered up, the request appears as an interrupt flag that the frame logic places in bit 0 of the slot 12 input word. While the link is powered down, the request drives the serial data-in wake line from low to high, and the line stays high until power-down ends. Frame serialisation and slot timing are handled elsewhere.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset the wake-enable mask reads 0. A write with `wr_sel`=0 stores the data, and a read with `rd_sel`=0 returns it.
- R2: Bits at and above `NUM_PINS` read as 0 in both registers, whatever is written or driven on the pins.
- R3: For a pin that is not a sticky input, the status bit (read with `rd_sel`=1) follows the live pin level through a two-flop synchroniser. This holds whether `cfg_dir` marks the pin as input (1) or output (0).
- R4: For a sticky input (`cfg_dir`=1, `cfg_sticky`=1), `cfg_pol`=1 latches a low-to-high transition and `cfg_pol`=0 latches a high-to-low transition. The opposite transition does not set the bit.
- R5: A status write (`wr_sel`=1) clears each sticky bit whose data bit is 0. Data bits of 1 have no effect. The write does not change the status of pins that are not sticky inputs.
- R6: If a clearing write and a new qualifying transition reach the same bit in the same cycle, the bit stays set.
- R7: With `link_down`=0, `gpio_int` is 1 exactly when some sticky-input status bit and its mask bit are both 1. With `link_down`=1, `gpio_int` is 0.
- R8: With `link_down`=1, a pending enabled event raises `sdata_wake`. The line stays high even after the status is cleared, and it drops once `link_down` is 0.
- R9: A set status bit whose mask bit is 0 raises neither `gpio_int` nor `sdata_wake`.
- R10: A pin that is already at its qualifying level when reset ends does not set its sticky bit. Only a transition seen after the synchroniser has filled counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (cold or register reset) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mask, 1 status |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 mask, 1 status |
| rd_data | output | 16 | Read data (combinational) |
| gpio_in | input | 16 | GPIO pin levels, asynchronous |
| cfg_dir | input | 16 | Per-pin direction, 1 = input |
| cfg_pol | input | 16 | Per-pin polarity, 1 = rising counts |
| cfg_sticky | input | 16 | Per-pin sticky enable |
| link_down | input | 1 | Link powered down |
| gpio_int | output | 1 | Interrupt flag for slot 12 bit 0 |
| sdata_wake | output | 1 | Wake drive on serial data-in |

## Verification
The hardest case to reach is R6, where a clearing write and a fresh qualifying transition land on the same bit in the same cycle. The bench counts the synchroniser stages from the cycle the pin changes, so that the write strobe is sampled on exactly the edge at which the detected transition is registered. The wake hold of R8 is reached by clearing the status while the link is still down, and then checking that the line stays high until power-down is released.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
    localparam int REG_W = 16;
    localparam int FILL_W = 3;

    typedef struct packed {
        logic [REG_W-1:0]  mask;
        logic [REG_W-1:0]  stat;
        logic [FILL_W-1:0] fill;
        logic              irq;
        logic              wake;
    } ctrl_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign prev = s3_q;
endmodule

// File: rtl/gpio_edge_sel.sv
module gpio_edge_sel #(
    parameter int W = 16
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ena,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise   = lvl[i] & ~prev[i];
        assign fall   = ~lvl[i] & prev[i];
        assign hit[i] = ena[i] & (pol[i] ? rise : fall);
    end
endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
    import gpio_wake_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        rd_sel,
    output logic [15:0] rd_data,
    input  logic [15:0] gpio_in,
    input  logic [15:0] cfg_dir,
    input  logic [15:0] cfg_pol,
    input  logic [15:0] cfg_sticky,
    input  logic        link_down,
    output logic        gpio_int,
    output logic        sdata_wake
);
    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((32'd1 << NUM_PINS) - 32'd1);

    ctrl_state_t st_d, st_q;
    logic [REG_W-1:0] lvl, prev, sticky_in, hit, clr;
    logic             any_evt, primed;

    gpio_sync #(.W(REG_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_in),
        .lvl  (lvl),
        .prev (prev)
    );

    assign sticky_in = cfg_dir & cfg_sticky & IMPL_MASK;
    assign primed    = st_q.fill[FILL_W-1];

    gpio_edge_sel #(.W(REG_W)) u_edge (
        .lvl (lvl),
        .prev(prev),
        .pol (cfg_pol),
        .ena (sticky_in & {REG_W{primed}}),
        .hit (hit)
    );

    always_comb begin
        st_d    = st_q;
        clr     = (wr_en && wr_sel) ? ~wr_data : '0;
        any_evt = |(st_q.stat & st_q.mask & sticky_in);

        st_d.fill = {st_q.fill[FILL_W-2:0], 1'b1};
        if (wr_en && !wr_sel)
            st_d.mask = wr_data & IMPL_MASK;

        // Edge wins over a same-cycle clear; non-sticky bits track the pin.
        st_d.stat = ((sticky_in & (hit | (st_q.stat & ~clr)))
                   | (~sticky_in & lvl)) & IMPL_MASK;

        st_d.irq  = !link_down && any_evt;
        st_d.wake = link_down && (st_q.wake || any_evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = (rd_sel ? st_q.stat : st_q.mask) & IMPL_MASK;
    assign gpio_int   = st_q.irq;
    assign sdata_wake = st_q.wake;
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk #(
    parameter int NUM_PINS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        link_down,
    input logic        gpio_int,
    input logic        sdata_wake,
    input logic [15:0] rd_data
);
    localparam logic [15:0] IMPL = 16'((32'd1 << NUM_PINS) - 32'd1);

    AST_INT_WAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpio_int && sdata_wake));                                    // R7
    AST_INT_OFF_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        link_down |=> !gpio_int);                                      // R7
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_wake && link_down) |=> sdata_wake);                     // R8
    AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !link_down |=> !sdata_wake);                                   // R8
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~IMPL) == 16'h0);                                   // R2
endmodule

bind gpio_wake_ctrl gpio_wake_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_down (link_down),
    .gpio_int  (gpio_int),
    .sdata_wake(sdata_wake),
    .rd_data   (rd_data)
);

// File: tb/tb_gpio_wake_ctrl.sv
module tb_gpio_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, link_down = 1'b0;
    logic [15:0] wr_data = '0, rd_data;
    logic [15:0] gpio_in = 16'h0003, cfg_dir = 16'hFFFF;
    logic [15:0] cfg_pol = 16'h0001, cfg_sticky = 16'h0003;
    logic        gpio_int, sdata_wake;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_wake_ctrl #(.NUM_PINS(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .gpio_in(gpio_in), .cfg_dir(cfg_dir),
        .cfg_pol(cfg_pol), .cfg_sticky(cfg_sticky), .link_down(link_down),
        .gpio_int(gpio_int), .sdata_wake(sdata_wake)
    );

    // {gpio, dir, expected status} with no sticky pins: level following (R3)
    localparam logic [47:0] VEC [4] = '{
        {16'hA5A5, 16'hFFFF, 16'h00A5},
        {16'h0F0F, 16'h0000, 16'h000F},
        {16'hFFFF, 16'h00F0, 16'h00FF},
        {16'h0000, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        logic [15:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(6);
        // R10: pin0 high (rising) and pin1 high (falling) through reset, no latch
        rd(1'b1, v); chk("R10", v, 16'h0000);
        rd(1'b0, v); chk("R1 mask reset", v, 16'h0000);
        chk("R7 int reset", {15'h0, gpio_int}, 16'h0);
        chk("R8 wake reset", {15'h0, sdata_wake}, 16'h0);

        // R4: both pins low: pin1 falling latches, pin0 falling ignored
        gpio_in = 16'h0000; settle(6);
        rd(1'b1, v); chk("R4 falling", v, 16'h0002);
        gpio_in = 16'h0003; settle(6);
        rd(1'b1, v); chk("R4 rising", v, 16'h0003);
        // R9: status set but mask 0
        chk("R9 no int", {15'h0, gpio_int}, 16'h0);
        // R5: ones keep, zero clears
        wr(1'b1, 16'hFFFE); settle(2);
        rd(1'b1, v); chk("R5 clear bit0", v, 16'h0002);
        wr(1'b1, 16'h0000); settle(2);
        rd(1'b1, v); chk("R5 clear all", v, 16'h0000);

        // R1/R2: mask write, unimplemented bits dropped
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R1 R2 mask", v, 16'h00FF);
        wr(1'b0, 16'h0002);

        // R7: link up, pin1 falls -> interrupt
        gpio_in = 16'h0001; settle(6);
        chk("R7 int set", {15'h0, gpio_int}, 16'h1);
        chk("R7 no wake", {15'h0, sdata_wake}, 16'h0);
        wr(1'b1, 16'h0000); settle(3);
        chk("R7 int clear", {15'h0, gpio_int}, 16'h0);

        // R8: link down, pin1 rise then fall -> wake, held after clear
        link_down = 1'b1;
        gpio_in = 16'h0003; settle(6);
        chk("R8 rise no wake", {15'h0, sdata_wake}, 16'h0);
        gpio_in = 16'h0001; settle(6);
        chk("R8 wake", {15'h0, sdata_wake}, 16'h1);
        chk("R7 int off down", {15'h0, gpio_int}, 16'h0);
        wr(1'b1, 16'h0000); settle(4);
        chk("R8 hold", {15'h0, sdata_wake}, 16'h1);
        link_down = 1'b0; settle(2);
        chk("R8 drop", {15'h0, sdata_wake}, 16'h0);
        chk("R7 no int after clear", {15'h0, gpio_int}, 16'h0);

        // R6: set bit0, drop pin, then collide clear with new rising edge
        wr(1'b0, 16'h0000);
        gpio_in = 16'h0000; settle(6);
        gpio_in = 16'h0001; settle(6);
        rd(1'b1, v); chk("R6 pre", v & 16'h0003, 16'h0001);
        gpio_in = 16'h0000; settle(6);
        gpio_in = 16'h0001;        // at negedge before edge k
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0000;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        rd(1'b1, v); chk("R6 collide", v & 16'h0003, 16'h0001);

        // R3: table of level-following vectors, stickiness off
        cfg_sticky = 16'h0000;
        for (int i = 0; i < 4; i++) begin
            gpio_in = VEC[i][47:32];
            cfg_dir = VEC[i][31:16];
            settle(5);
            rd(1'b1, v); chk("R3 level", v, VEC[i][15:0]);
        end
        // R5: write to non-sticky bits has no effect; R2 on high pins
        gpio_in = 16'hFFFF; settle(5);
        wr(1'b1, 16'h0000); settle(1);
        rd(1'b1, v); chk("R5 R2 non-sticky", v, 16'h00FF);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule